// File: doc/BRIEF.md
# Floating-Point Coprocessor Access Gate

This block holds the single control register that decides whether floating-point instructions may run, and at which privilege level. Software reaches the register through a small bus slave port. The port has a select, a write enable, a 32-bit address, write data and the privilege level of the requester. Each access that hits the register gets a response in the next cycle. The instruction side presents a floating-point instruction valid flag together with the current privilege level. In the same cycle, the gate returns either an allow or a usage-fault request.

Two 2-bit fields sit at bits 20 to 23 and control coprocessors 10 and 11. Both fields must permit the current privilege level before an instruction is allowed. Only privileged code can read or write the register. An unprivileged access is refused with a bus error.

The bus side is a four-state machine: `S_IDLE`, `S_RD_ACK`, `S_WR_ACK` and `S_DENY`. From any state, the next state depends on the request in the current cycle:
- a privileged read that hits the register goes to `S_RD_ACK`;
- a privileged write that hits the register goes to `S_WR_ACK`;
- an unprivileged hit goes to `S_DENY`;
- no hit goes to `S_IDLE`.

`S_RD_ACK` presents the captured read word and the acknowledge. `S_WR_ACK` presents the acknowledge only. `S_DENY` presents the error with zero data.

Top module: `fp_access_gate`

## Requirements
- R1: The register answers only at address 0xE000ED88. An access to any other address produces neither acknowledge nor error and leaves the register unchanged.
- R2: The register resets to zero, so every floating-point instruction is blocked after reset.
- R3: Bits [21:20] hold the coprocessor 10 field and bits [23:22] hold the coprocessor 11 field. A privileged write stores them, and a read returns them. All other bits read as zero, and writes to them are ignored.
- R4: Field encoding: 00 means no access, 01 means privileged code only, 11 means full access, and 10 is reserved and acts as no access. A privilege input of 1 means privileged.
- R5: An instruction is allowed only when both fields permit the current privilege level.
- R6: An unprivileged read returns zero with the error flag set. An unprivileged write is dropped with the error flag set, and no acknowledge is given.
- R7: A privileged access that hits the register is acknowledged, with data for a read, in the cycle after it is presented.
- R8: When the valid flag is high, exactly one of allow and fault is high, and each lasts one cycle per valid cycle. When the valid flag is low, both are low.
- R9: A written value governs the gate from the cycle after the write. The cycle of the write itself still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Access address |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Requester privilege, 1 = privileged |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access completed |
| bus_err | output | 1 | Access refused |
| fp_valid | input | 1 | Floating-point instruction presented |
| fp_priv | input | 1 | Privilege of that instruction, 1 = privileged |
| fp_allow | output | 1 | Instruction may execute |
| fp_fault | output | 1 | Usage-fault request for a blocked instruction |

## Verification
The bench targets the following corner cases:
- The reserved encoding 10. A design that treats it as full access would let user code run.
- Mixed fields such as 11 with 01. A gate that checks only one coprocessor would allow user code here.
- Unprivileged writes. A design that drops only the data but not the store would have its register corrupted by user code.
- Writes of all ones. A design that does not mask the read word would return ones outside bits 20 to 23.
- An instruction presented in the very cycle of a write. A design that forwards write data would allow that instruction too early.
- Off-address accesses. A design with loose address decode would acknowledge them.

// File: rtl/fpgate_pkg.sv
package fpgate_pkg;

    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned DATA_W    = 32;
    localparam logic [31:0] CTRL_ADDR = 32'hE000_ED88;
    localparam int unsigned FIELD_LSB = 20;
    localparam int unsigned FIELD_W   = 2;
    localparam int unsigned NUM_CP    = 2;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_PRIV = 2'b01,
        ACC_RSVD = 2'b10,
        ACC_FULL = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RD_ACK = 2'd1,
        S_WR_ACK = 2'd2,
        S_DENY   = 2'd3
    } bus_state_e;

    // Does one coprocessor field permit an instruction at this privilege?
    function automatic logic field_permits(input acc_e fld, input logic priv);
        logic ok;
        unique case (fld)
            ACC_FULL: ok = 1'b1;
            ACC_PRIV: ok = priv;
            ACC_NONE: ok = 1'b0;
            ACC_RSVD: ok = 1'b0;
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/fpgate_ctrl_reg.sv
module fpgate_ctrl_reg #(
    parameter int unsigned NUM_CP  = fpgate_pkg::NUM_CP,
    parameter int unsigned FIELD_W = fpgate_pkg::FIELD_W,
    localparam int unsigned BITS   = NUM_CP * FIELD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [BITS-1:0] wr_fields,
    output logic [BITS-1:0] fields
);

    logic [BITS-1:0] fields_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else if (wr_en) begin
            fields_q <= wr_fields;
        end
    end

    assign fields = fields_q;

endmodule

// File: rtl/fpgate_perm.sv
module fpgate_perm #(
    parameter int unsigned NUM_CP = fpgate_pkg::NUM_CP,
    localparam int unsigned FW    = fpgate_pkg::FIELD_W,
    localparam int unsigned BITS  = NUM_CP * FW
) (
    input  logic [BITS-1:0] fields,
    input  logic            fp_valid,
    input  logic            fp_priv,
    output logic            fp_allow,
    output logic            fp_fault
);
    import fpgate_pkg::*;

    logic [NUM_CP-1:0] cp_ok;

    for (genvar i = 0; i < NUM_CP; i++) begin : g_cp
        assign cp_ok[i] = field_permits(acc_e'(fields[i*FW +: FW]), fp_priv);
    end

    logic permit;
    assign permit   = &cp_ok;
    assign fp_allow = fp_valid &  permit;
    assign fp_fault = fp_valid & ~permit;

endmodule

// File: rtl/fpgate_bus_fsm.sv
module fpgate_bus_fsm #(
    parameter int unsigned     ADDR_W   = fpgate_pkg::ADDR_W,
    parameter int unsigned     DATA_W   = fpgate_pkg::DATA_W,
    parameter logic [ADDR_W-1:0] BASE   = fpgate_pkg::CTRL_ADDR,
    parameter int unsigned     FLD_LSB  = fpgate_pkg::FIELD_LSB,
    parameter int unsigned     FLD_BITS = fpgate_pkg::NUM_CP * fpgate_pkg::FIELD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [FLD_BITS-1:0] wfields,
    input  logic                priv,
    input  logic [FLD_BITS-1:0] cur_fields,
    output logic                wr_en,
    output logic [FLD_BITS-1:0] wr_fields,
    output logic [DATA_W-1:0]   rdata,
    output logic                ack,
    output logic                err
);
    import fpgate_pkg::*;

    bus_state_e state_q, state_d;
    logic [DATA_W-1:0] rd_word, rdata_q;
    logic hit;

    assign hit       = sel && (addr == BASE);
    assign wr_en     = hit && wr && priv;
    assign wr_fields = wfields;

    always_comb begin
        rd_word = '0;
        rd_word[FLD_LSB +: FLD_BITS] = cur_fields;
    end

    // Next-state: every state leaves on the request seen this cycle.
    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE, S_RD_ACK, S_WR_ACK, S_DENY: begin
                if (!hit)       state_d = S_IDLE;
                else if (!priv) state_d = S_DENY;
                else if (wr)    state_d = S_WR_ACK;
                else            state_d = S_RD_ACK;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (hit && priv && !wr) rdata_q <= rd_word;
        end
    end

    // Outputs by state.
    always_comb begin
        ack   = 1'b0;
        err   = 1'b0;
        rdata = '0;
        unique case (state_q)
            S_IDLE:   ;
            S_RD_ACK: begin ack = 1'b1; rdata = rdata_q; end
            S_WR_ACK: ack = 1'b1;
            S_DENY:   err = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/fp_access_gate.sv
module fp_access_gate #(
    parameter int unsigned       ADDR_W    = fpgate_pkg::ADDR_W,
    parameter int unsigned       DATA_W    = fpgate_pkg::DATA_W,
    parameter logic [ADDR_W-1:0] BASE      = fpgate_pkg::CTRL_ADDR,
    parameter int unsigned       FIELD_LSB = fpgate_pkg::FIELD_LSB,
    parameter int unsigned       NUM_CP    = fpgate_pkg::NUM_CP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_priv,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic              bus_err,
    input  logic              fp_valid,
    input  logic              fp_priv,
    output logic              fp_allow,
    output logic              fp_fault
);
    localparam int unsigned FLD_BITS = NUM_CP * fpgate_pkg::FIELD_W;
    localparam logic [DATA_W-1:0] FLD_MASK =
        ((DATA_W'(1) << FLD_BITS) - DATA_W'(1)) << FIELD_LSB;

    logic [FLD_BITS-1:0] fields_q, wr_fields;
    logic                wr_en;
    logic                unused_wdata;

    assign unused_wdata = ^(bus_wdata & ~FLD_MASK);

    fpgate_bus_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE),
        .FLD_LSB(FIELD_LSB), .FLD_BITS(FLD_BITS)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr),
        .addr(bus_addr), .wfields(bus_wdata[FIELD_LSB +: FLD_BITS]),
        .priv(bus_priv), .cur_fields(fields_q), .wr_en(wr_en),
        .wr_fields(wr_fields), .rdata(bus_rdata), .ack(bus_ack), .err(bus_err)
    );

    fpgate_ctrl_reg #(.NUM_CP(NUM_CP), .FIELD_W(fpgate_pkg::FIELD_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_fields(wr_fields), .fields(fields_q)
    );

    fpgate_perm #(.NUM_CP(NUM_CP)) u_perm (
        .fields(fields_q), .fp_valid(fp_valid), .fp_priv(fp_priv),
        .fp_allow(fp_allow), .fp_fault(fp_fault)
    );

endmodule

// File: rtl/fpgate_checks.sv
module fpgate_checks #(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE      = 32'hE000_ED88,
    parameter int unsigned       FIELD_LSB = 20,
    parameter int unsigned       FLD_BITS  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_priv,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                bus_ack,
    input logic                bus_err,
    input logic                fp_valid,
    input logic                fp_allow,
    input logic                fp_fault,
    input logic [FLD_BITS-1:0] fields
);
    localparam logic [DATA_W-1:0] MASK =
        ((DATA_W'(1) << FLD_BITS) - DATA_W'(1)) << FIELD_LSB;

    logic hit;
    assign hit = bus_sel && (bus_addr == BASE);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fp_allow && fp_fault));
    p_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_allow || fp_fault) |-> fp_valid);
    p_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fp_valid |-> (fp_allow || fp_fault));
    p_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (bus_ack || bus_err));
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !(bus_ack || bus_err));
    p_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !bus_priv) |=> (bus_err && !bus_ack && bus_rdata == '0));
    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !bus_priv) |=> $stable(fields));
    p_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> ((bus_rdata & ~MASK) == '0));

endmodule

bind fp_access_gate fpgate_checks #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE),
    .FIELD_LSB(FIELD_LSB), .FLD_BITS(FLD_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_priv(bus_priv), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .fp_valid(fp_valid), .fp_allow(fp_allow),
    .fp_fault(fp_fault), .fields(fields_q)
);

// File: tb/sim_fp_access_gate.sv
module sim_fp_access_gate;

    localparam logic [31:0] REG = 32'hE000_ED88;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic        bus_ack, bus_err;
    logic        fp_valid = 1'b0, fp_priv = 1'b0;
    logic        fp_allow, fp_fault;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    fp_access_gate u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .fp_valid(fp_valid), .fp_priv(fp_priv),
        .fp_allow(fp_allow), .fp_fault(fp_fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, response sampled at the next negedge.
    task automatic bus_op(input logic wr, input logic [31:0] addr, input logic [31:0] data,
                          input logic priv, output logic [31:0] rd,
                          output logic ack, output logic err);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = data; bus_priv = priv;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd = bus_rdata; ack = bus_ack; err = bus_err;
    endtask

    task automatic fp_probe(input string req, input logic priv, input logic exp_allow);
        fp_valid = 1'b1; fp_priv = priv;
        #1;
        check(req, {30'b0, fp_allow, fp_fault}, {30'b0, exp_allow, !exp_allow});
        fp_valid = 1'b0;
        #1;
    endtask

    task automatic priv_write(input string req, input logic [31:0] data);
        logic [31:0] rd; logic ack, err;
        bus_op(1'b1, REG, data, 1'b1, rd, ack, err);
        check(req, {30'b0, ack, err}, 32'h2);
    endtask

    task automatic priv_read(input string req, input logic [31:0] exp);
        logic [31:0] rd; logic ack, err;
        bus_op(1'b0, REG, 32'h0, 1'b1, rd, ack, err);
        check(req, {30'b0, ack, err}, 32'h2);
        check(req, rd, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R2 outputs idle", {29'b0, bus_ack, bus_err, fp_allow}, 32'h0);
        fp_probe("R2 priv blocked", 1'b1, 1'b0);
        fp_probe("R2 user blocked", 1'b0, 1'b0);
        priv_read("R2 R7 reset read", 32'h0);
    endtask

    task automatic t_fields;
        priv_write("R7 write ack", 32'h00F0_0000);
        priv_read("R3 readback", 32'h00F0_0000);
        fp_probe("R4 full user", 1'b0, 1'b1);
        fp_probe("R4 full priv", 1'b1, 1'b1);
        priv_write("R3 write ones", 32'hFFFF_FFFF);
        priv_read("R3 pad zero", 32'h00F0_0000);
        priv_write("R3 write", 32'hFF0F_FFFF);
        priv_read("R3 clear", 32'h0000_0000);
    endtask

    task automatic t_encoding;
        priv_write("R4 priv-only", 32'h0050_0000);
        fp_probe("R4 01 user", 1'b0, 1'b0);
        fp_probe("R4 01 priv", 1'b1, 1'b1);
        priv_write("R4 reserved", 32'h00A0_0000);
        fp_probe("R4 10 priv", 1'b1, 1'b0);
        fp_probe("R4 10 user", 1'b0, 1'b0);
        priv_write("R5 mixed", 32'h0070_0000);  // cp10=11, cp11=01
        fp_probe("R5 mixed priv", 1'b1, 1'b1);
        fp_probe("R5 mixed user", 1'b0, 1'b0);
        priv_write("R5 cp11 rsvd", 32'h00B0_0000); // cp10=11, cp11=10
        fp_probe("R5 one reserved", 1'b1, 1'b0);
    endtask

    task automatic t_unpriv;
        logic [31:0] rd; logic ack, err;
        priv_write("R6 setup", 32'h00F0_0000);
        bus_op(1'b1, REG, 32'h0, 1'b0, rd, ack, err);
        check("R6 user write err", {30'b0, ack, err}, 32'h1);
        bus_op(1'b0, REG, 32'h0, 1'b0, rd, ack, err);
        check("R6 user read err", {30'b0, ack, err}, 32'h1);
        check("R6 user read zero", rd, 32'h0);
        priv_read("R6 write dropped", 32'h00F0_0000);
        fp_probe("R6 still full", 1'b0, 1'b1);
    endtask

    task automatic t_addr;
        logic [31:0] rd; logic ack, err;
        bus_op(1'b1, REG + 32'd4, 32'h0, 1'b1, rd, ack, err);
        check("R1 off address silent", {30'b0, ack, err}, 32'h0);
        bus_op(1'b0, 32'h6000_ED88, 32'h0, 1'b1, rd, ack, err);
        check("R1 off address read", {30'b0, ack, err}, 32'h0);
        priv_read("R1 unchanged", 32'h00F0_0000);
    endtask

    task automatic t_timing;
        priv_write("R9 clear", 32'h0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = REG; bus_wdata = 32'h00F0_0000; bus_priv = 1'b1;
        fp_probe("R9 old value in write cycle", 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R9 ack", {31'b0, bus_ack}, 32'h1);
        fp_probe("R9 new value next cycle", 1'b0, 1'b1);
    endtask

    task automatic t_idle_fp;
        fp_valid = 1'b0; fp_priv = 1'b1;
        #1;
        check("R8 no valid no output", {30'b0, fp_allow, fp_fault}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_encoding();
        t_unpriv();
        t_addr();
        t_timing();
        t_idle_fp();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule